// File: doc/BRIEF.md
# Single-Precision Floating-Point Subtractor

This block computes `dest - src` on two 32-bit IEEE-754 single-precision words and returns a correctly rounded 32-bit result with four exception flags: invalid, overflow, underflow and inexact. The rounding direction is chosen per operation by a 2-bit mode input. A second input marks the source word as the product of an integer conversion. When set, an all-zero-exponent source is taken as positive zero whatever its sign bit.

Finite operands are aligned and added or subtracted with guard, round and sticky bits. The sum is normalised, rounded once, and checked for the top and bottom of the exponent range. Zeros, infinities and NaNs are resolved by a separate special-case stage. That stage applies the signed-zero rules. Subnormal inputs and subnormal results are flushed to zero.

A request presented with `in_valid` produces its result on the outputs one clock later, marked by `out_valid`. The outputs hold their last value until the next request.

Top module: `fp32_sub`

## Requirements
- R1: For finite operands the result is `dest - src`, rounded by `rmode_i`. The encodings are 00 round to nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. `inexact_o` is set whenever the rounded value differs from the exact difference.
- R2: When two like-signed finite operands give an exact zero difference, the result is +0 (0x00000000), except in mode 01, where it is -0 (0x80000000). No flag is set.
- R3: +0 minus -0 gives +0, and -0 minus +0 gives -0, in every rounding mode.
- R4: When `src_int_i` is 1 and the source exponent field (bits 30:23) is zero, the source is taken as +0 regardless of its bit 31.
- R5: When exactly one operand is infinite, the result is an infinity with no flag set. An infinite dest keeps its own sign, and an infinite src gives an infinity of the opposite sign.
- R6: Two infinities of the same sign give the default quiet NaN 0x7FC00000 and set `invalid_o`. Infinities of opposite sign give the dest infinity.
- R7: A NaN operand (exponent 0xFF, fraction nonzero) gives 0x7FC00000. `invalid_o` is set only when a NaN operand is signaling, meaning fraction bit 22 is clear.
- R8: When the rounded exponent reaches 255, `overflow_o` and `inexact_o` are set. The result is infinity or the largest finite magnitude (exponent 0xFE, fraction all ones), according to the mode and sign. Mode 00 gives infinity and mode 11 the largest finite value. Mode 01 gives infinity for a negative result and the largest finite value for a positive one. Mode 10 gives the reverse.
- R9: An input with a zero exponent field and a nonzero fraction is treated as a zero with its own sign.
- R10: When a nonzero difference, once normalised and before rounding, has a biased exponent below 1, the result is a zero carrying the difference's sign. `underflow_o` and `inexact_o` are set.
- R11: Result and flags appear one clock after `in_valid`, together with a one-cycle `out_valid`. While `in_valid` is low they hold their values. Reset clears `out_valid`, the result and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| dest_i | input | 32 | Minuend, single-precision |
| src_i | input | 32 | Subtrahend, single-precision |
| src_int_i | input | 1 | Source came from an integer conversion |
| rmode_i | input | 2 | Rounding mode (00 nearest, 01 down, 10 up, 11 toward zero) |
| out_valid | output | 1 | Result registered this cycle |
| result_o | output | 32 | Rounded difference |
| invalid_o | output | 1 | Invalid-operation flag |
| overflow_o | output | 1 | Overflow flag |
| underflow_o | output | 1 | Underflow (flush) flag |
| inexact_o | output | 1 | Inexact flag |

## Verification
Several relations hold on every cycle and are checked continuously: invalid always comes with the default NaN, and overflow always comes with inexact and a saturated exponent. Underflow always leaves a zero magnitude, and an infinity that does not come from overflow is never inexact. The one-cycle latency and hold behaviour, the signed-zero identities and the mode-dependent sign of equal-operand cancellation are also checked for every request. Correct rounding of finite differences cannot be stated as a per-cycle property. It is shown only by the bench, which compares each result with an exact wide-integer model across random operand mixes, deep cancellation, and the edges of the range near overflow and underflow.

// File: rtl/fp32_sub_pkg.sv
package fp32_sub_pkg;

    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;          // hidden bit plus fraction
    localparam int EXT_W   = SIG_W + 3;           // plus guard, round, sticky
    localparam int SH_W    = SIG_W + EXT_W - 1;   // alignment window
    localparam int XE_W    = EXP_W + 2;           // working exponent width
    localparam int LZ_W    = $clog2(EXT_W + 1);
    localparam int EXP_MAX = (1 << EXP_W) - 1;

    localparam logic [WORD_W-1:0] QNAN_DEFAULT =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_DOWN    = 2'b01,
        RM_UP      = 2'b10,
        RM_ZERO    = 2'b11
    } rmode_e;

    typedef enum logic [2:0] {
        K_ZERO,
        K_NORM,
        K_INF,
        K_QNAN,
        K_SNAN
    } kind_e;

    // Magnitude part used by the arithmetic path
    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
    } mag_t;

    typedef struct packed {
        mag_t  mag;
        kind_e kind;
    } opnd_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              invalid;
        logic              overflow;
        logic              underflow;
        logic              inexact;
    } outcome_t;

    function automatic logic [WORD_W-1:0] word_inf(input logic s);
        return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] word_zero(input logic s);
        return {s, {(WORD_W-1){1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] word_maxfin(input logic s);
        return {s, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    endfunction

    // Increment decision from the kept lsb and guard/round/sticky
    function automatic logic round_incr(input rmode_e rm, input logic sign,
                                        input logic lsb, input logic g,
                                        input logic r, input logic s);
        logic lost;
        lost = g | r | s;
        case (rm)
            RM_NEAREST: return g & (r | s | lsb);
            RM_DOWN:    return lost & sign;
            RM_UP:      return lost & ~sign;
            default:    return 1'b0;
        endcase
    endfunction

    // Saturation value on exponent overflow
    function automatic logic [WORD_W-1:0] word_overflow(input rmode_e rm, input logic s);
        case (rm)
            RM_NEAREST: return word_inf(s);
            RM_DOWN:    return s ? word_inf(s) : word_maxfin(s);
            RM_UP:      return s ? word_maxfin(s) : word_inf(s);
            default:    return word_maxfin(s);
        endcase
    endfunction

endpackage

// File: rtl/fp32_sub_unpack.sv
module fp32_sub_unpack
    import fp32_sub_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic              int_src_i,
    input  logic              negate_i,
    output opnd_t             op_o
);

    logic              s_bit;
    logic [EXP_W-1:0]  e_fld;
    logic [FRAC_W-1:0] f_fld;

    always_comb begin
        s_bit = word_i[WORD_W-1];
        e_fld = word_i[WORD_W-2 -: EXP_W];
        f_fld = word_i[FRAC_W-1:0];

        op_o.mag.sign = s_bit ^ negate_i;
        op_o.mag.exp  = e_fld;
        op_o.mag.sig  = {1'b1, f_fld};
        op_o.kind     = K_NORM;

        if (e_fld == '0) begin
            // zero or subnormal: flushed to a zero of its sign
            op_o.kind    = K_ZERO;
            op_o.mag.sig = '0;
            if (int_src_i) begin
                op_o.mag.sign = negate_i;   // integer zero counts as +0
            end
        end else if (e_fld == {EXP_W{1'b1}}) begin
            op_o.mag.sig = '0;
            if (f_fld == '0) begin
                op_o.kind = K_INF;
            end else if (f_fld[FRAC_W-1]) begin
                op_o.kind = K_QNAN;
            end else begin
                op_o.kind = K_SNAN;
            end
        end
    end

endmodule

// File: rtl/fp32_sub_core.sv
module fp32_sub_core
    import fp32_sub_pkg::*;
(
    input  mag_t     a_i,
    input  mag_t     b_i,
    input  rmode_e   rm_i,
    output outcome_t res_o
);

    mag_t              big, sml;
    logic [EXP_W-1:0]  diff;
    logic [SH_W-1:0]   shifted;
    logic [EXT_W-1:0]  big_x, sml_x;
    logic              subtract;
    logic [EXT_W:0]    raw;
    logic [LZ_W-1:0]   lz;
    logic [EXT_W-1:0]  norm;
    logic [XE_W-1:0]   exp_n, exp_r;
    logic              tiny;
    logic              up, lost;
    logic [SIG_W:0]    rounded;
    logic [FRAC_W-1:0] frac_r;

    // Order by magnitude and align the smaller operand
    always_comb begin
        if ({a_i.exp, a_i.sig} >= {b_i.exp, b_i.sig}) begin
            big = a_i;
            sml = b_i;
        end else begin
            big = b_i;
            sml = a_i;
        end
        diff    = big.exp - sml.exp;
        big_x   = {big.sig, 3'b000};
        shifted = {sml.sig, {(SH_W-SIG_W){1'b0}}} >> diff;
        if (diff > EXP_W'(EXT_W - 1)) begin
            sml_x = {{(EXT_W-1){1'b0}}, |sml.sig};
        end else begin
            sml_x = shifted[SH_W-1 -: EXT_W]
                  | {{(EXT_W-1){1'b0}}, |shifted[SH_W-EXT_W-1:0]};
        end
        subtract = big.sign ^ sml.sign;
        raw = subtract ? ({1'b0, big_x} - {1'b0, sml_x})
                       : ({1'b0, big_x} + {1'b0, sml_x});
    end

    // Leading-zero count and normalisation
    always_comb begin
        lz = LZ_W'(EXT_W);
        for (int i = 0; i < EXT_W; i++) begin
            if (raw[i]) begin
                lz = LZ_W'(EXT_W - 1 - i);
            end
        end
        if (raw[EXT_W]) begin
            norm  = {raw[EXT_W:2], raw[1] | raw[0]};
            exp_n = XE_W'(big.exp) + XE_W'(1);
            tiny  = 1'b0;
        end else begin
            norm  = raw[EXT_W-1:0] << lz;
            exp_n = XE_W'(big.exp) - XE_W'(lz);
            tiny  = XE_W'(big.exp) <= XE_W'(lz);
        end
    end

    // Rounding and range checks
    always_comb begin
        lost    = |norm[2:0];
        up      = round_incr(rm_i, big.sign, norm[3], norm[2], norm[1], norm[0]);
        rounded = {1'b0, norm[EXT_W-1:3]} + (SIG_W+1)'(up);
        if (rounded[SIG_W]) begin
            exp_r  = exp_n + XE_W'(1);
            frac_r = rounded[FRAC_W:1];
        end else begin
            exp_r  = exp_n;
            frac_r = rounded[FRAC_W-1:0];
        end

        res_o = '0;
        if (raw == '0) begin
            res_o.word = word_zero(rm_i == RM_DOWN);
        end else if (tiny) begin
            res_o.word      = word_zero(big.sign);
            res_o.underflow = 1'b1;
            res_o.inexact   = 1'b1;
        end else if (exp_r >= XE_W'(EXP_MAX)) begin
            res_o.word     = word_overflow(rm_i, big.sign);
            res_o.overflow = 1'b1;
            res_o.inexact  = 1'b1;
        end else begin
            res_o.word    = {big.sign, exp_r[EXP_W-1:0], frac_r};
            res_o.inexact = lost;
        end
    end

endmodule

// File: rtl/fp32_sub_special.sv
module fp32_sub_special
    import fp32_sub_pkg::*;
(
    input  kind_e    a_kind_i,
    input  logic     a_sign_i,
    input  kind_e    b_kind_i,
    input  logic     b_sign_i,
    input  rmode_e   rm_i,
    input  outcome_t core_i,
    output outcome_t res_o
);

    logic a_nan, b_nan, any_snan;

    always_comb begin
        a_nan    = (a_kind_i == K_QNAN) || (a_kind_i == K_SNAN);
        b_nan    = (b_kind_i == K_QNAN) || (b_kind_i == K_SNAN);
        any_snan = (a_kind_i == K_SNAN) || (b_kind_i == K_SNAN);

        res_o = '0;
        if (a_nan || b_nan) begin
            res_o.word    = QNAN_DEFAULT;
            res_o.invalid = any_snan;
        end else if (a_kind_i == K_INF && b_kind_i == K_INF) begin
            // b carries the negated source sign
            if (a_sign_i != b_sign_i) begin
                res_o.word    = QNAN_DEFAULT;
                res_o.invalid = 1'b1;
            end else begin
                res_o.word = word_inf(a_sign_i);
            end
        end else if (a_kind_i == K_INF) begin
            res_o.word = word_inf(a_sign_i);
        end else if (b_kind_i == K_INF) begin
            res_o.word = word_inf(b_sign_i);
        end else if (a_kind_i == K_ZERO && b_kind_i == K_ZERO) begin
            res_o.word = (a_sign_i == b_sign_i) ? word_zero(a_sign_i)
                                                : word_zero(rm_i == RM_DOWN);
        end else begin
            res_o = core_i;
        end
    end

endmodule

// File: rtl/fp32_sub.sv
module fp32_sub
    import fp32_sub_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] dest_i,
    input  logic [31:0] src_i,
    input  logic        src_int_i,
    input  logic [1:0]  rmode_i,
    output logic        out_valid,
    output logic [31:0] result_o,
    output logic        invalid_o,
    output logic        overflow_o,
    output logic        underflow_o,
    output logic        inexact_o
);

    opnd_t    op_a, op_b;
    rmode_e   rm;
    outcome_t core_res, final_res, held;
    logic     valid_q;

    assign rm = rmode_e'(rmode_i);

    fp32_sub_unpack u_unpack_dest (
        .word_i    (dest_i),
        .int_src_i (1'b0),
        .negate_i  (1'b0),
        .op_o      (op_a)
    );

    // The subtrahend enters with its sign flipped, so the datapath adds
    fp32_sub_unpack u_unpack_src (
        .word_i    (src_i),
        .int_src_i (src_int_i),
        .negate_i  (1'b1),
        .op_o      (op_b)
    );

    fp32_sub_core u_core (
        .a_i   (op_a.mag),
        .b_i   (op_b.mag),
        .rm_i  (rm),
        .res_o (core_res)
    );

    fp32_sub_special u_special (
        .a_kind_i (op_a.kind),
        .a_sign_i (op_a.mag.sign),
        .b_kind_i (op_b.kind),
        .b_sign_i (op_b.mag.sign),
        .rm_i     (rm),
        .core_i   (core_res),
        .res_o    (final_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                held <= final_res;
            end
        end
    end

    assign out_valid   = valid_q;
    assign result_o    = held.word;
    assign invalid_o   = held.invalid;
    assign overflow_o  = held.overflow;
    assign underflow_o = held.underflow;
    assign inexact_o   = held.inexact;

endmodule

// File: rtl/fp32_sub_chk.sv
module fp32_sub_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] dest_i,
    input logic [31:0] src_i,
    input logic        src_int_i,
    input logic [1:0]  rmode_i,
    input logic        out_valid,
    input logic [31:0] result_o,
    input logic        invalid_o,
    input logic        overflow_o,
    input logic        underflow_o,
    input logic        inexact_o
);

    // R6 and R7: an invalid result is always the default quiet NaN
    p_invalid_nan_r6: assert property (@(posedge clk) disable iff (rst)
        invalid_o |-> result_o == 32'h7FC0_0000);

    p_no_overflow_exact_r8: assert property (@(posedge clk) disable iff (rst)
        overflow_o |-> inexact_o && !underflow_o && result_o[30:23] >= 8'hFE);

    p_flush_zero_r10: assert property (@(posedge clk) disable iff (rst)
        underflow_o |-> result_o[30:0] == 31'd0 && inexact_o && !overflow_o);

    // R5: an infinity that did not come from overflow is exact
    p_inf_exact_r5: assert property (@(posedge clk) disable iff (rst)
        (result_o[30:0] == 31'h7F80_0000 && !overflow_o) |-> !inexact_o && !underflow_o);

    p_latency_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(result_o) && $stable(inexact_o));

    p_pos_minus_negzero_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dest_i == 32'h0000_0000 && src_i == 32'h8000_0000 && !src_int_i)
        |=> result_o == 32'h0000_0000 && !inexact_o);

    p_neg_minus_poszero_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dest_i == 32'h8000_0000 && src_i == 32'h0000_0000)
        |=> result_o == 32'h8000_0000 && !inexact_o);

    // R2: equal finite operands cancel to a zero whose sign follows the mode
    p_cancel_sign_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dest_i == src_i && dest_i[30:23] != 8'hFF && !src_int_i)
        |=> result_o == (($past(rmode_i) == 2'b01) ? 32'h8000_0000 : 32'h0000_0000));

endmodule

bind fp32_sub fp32_sub_chk u_fp32_sub_chk (.*);

// File: tb/tb_fp32_sub.sv
module tb_fp32_sub;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] dest_i = '0;
    logic [31:0] src_i = '0;
    logic        src_int_i = 1'b0;
    logic [1:0]  rmode_i = 2'b00;
    logic        out_valid;
    logic [31:0] result_o;
    logic        invalid_o, overflow_o, underflow_o, inexact_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fp32_sub dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .dest_i(dest_i), .src_i(src_i), .src_int_i(src_int_i), .rmode_i(rmode_i),
        .out_valid(out_valid), .result_o(result_o),
        .invalid_o(invalid_o), .overflow_o(overflow_o),
        .underflow_o(underflow_o), .inexact_o(inexact_o)
    );

    // Exact model: magnitudes as wide integers in units of 2^-149
    function automatic logic [35:0] ref_sub(input logic [31:0] d, input logic [31:0] s,
                                            input logic isint, input logic [1:0] rm);
        logic [300:0] dm, sm, mg, lowmask;
        logic [24:0]  kept;
        logic [31:0]  sat;
        logic [7:0]   de, se;
        logic         dsg, tsg, sg, half, below, up, dnan, snan;
        int           p, e;
        de   = d[30:23];
        se   = s[30:23];
        dnan = (de == 8'hFF) && (d[22:0] != 0);
        snan = (se == 8'hFF) && (s[22:0] != 0);
        if (dnan || snan)
            return {32'h7FC0_0000, (dnan && !d[22]) || (snan && !s[22]), 3'b000};
        dsg = d[31];
        tsg = (isint && se == 8'h00) ? 1'b1 : ~s[31];
        if (de == 8'hFF && se == 8'hFF)
            return (dsg != tsg) ? {32'h7FC0_0000, 4'b1000} : {dsg, 8'hFF, 23'd0, 4'b0000};
        if (de == 8'hFF) return {dsg, 8'hFF, 23'd0, 4'b0000};
        if (se == 8'hFF) return {tsg, 8'hFF, 23'd0, 4'b0000};
        dm = (de == 0) ? '0 : (301'({1'b1, d[22:0]}) << (de - 1));
        sm = (se == 0) ? '0 : (301'({1'b1, s[22:0]}) << (se - 1));
        if (dm == 0 && sm == 0)
            return {((dsg == tsg) ? dsg : (rm == 2'b01)), 31'd0, 4'b0000};
        if (dsg == tsg) begin
            mg = dm + sm; sg = dsg;
        end else if (dm >= sm) begin
            mg = dm - sm; sg = dsg;
        end else begin
            mg = sm - dm; sg = tsg;
        end
        if (mg == 0) return {(rm == 2'b01), 31'd0, 4'b0000};
        p = 0;
        for (int i = 0; i < 301; i++) if (mg[i]) p = i;
        e = p - 22;
        if (e < 1) return {sg, 31'd0, 4'b0011};
        kept = 25'(mg >> (p - 23));
        if (p >= 24) begin
            half    = mg[p-24];
            lowmask = (301'(1) << (p - 24)) - 301'(1);
            below   = |(mg & lowmask);
        end else begin
            half  = 1'b0;
            below = 1'b0;
        end
        case (rm)
            2'b00:   up = half && (below || kept[0]);
            2'b01:   up = (half || below) && sg;
            2'b10:   up = (half || below) && !sg;
            default: up = 1'b0;
        endcase
        kept = kept + 25'(up);
        if (kept[24]) begin
            e    = e + 1;
            kept = kept >> 1;
        end
        if (e >= 255) begin
            case (rm)
                2'b00:   sat = {sg, 8'hFF, 23'd0};
                2'b01:   sat = sg ? {sg, 8'hFF, 23'd0} : {sg, 8'hFE, 23'h7FFFFF};
                2'b10:   sat = sg ? {sg, 8'hFE, 23'h7FFFFF} : {sg, 8'hFF, 23'd0};
                default: sat = {sg, 8'hFE, 23'h7FFFFF};
            endcase
            return {sat, 4'b0101};
        end
        return {sg, 8'(e), kept[22:0], 3'b000, half || below};
    endfunction

    task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [31:0] d, input logic [31:0] s,
                          input logic isint, input logic [1:0] rm);
        @(negedge clk);
        dest_i = d; src_i = s; src_int_i = isint; rmode_i = rm; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, {out_valid, result_o, invalid_o, overflow_o, underflow_o, inexact_o},
              {1'b1, ref_sub(d, s, isint, rm)});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    function automatic logic [31:0] gen_word(input logic [7:0] near_exp, input bit use_near);
        logic [31:0] r;
        logic [7:0]  e;
        r = $urandom;
        case ($urandom % 16)
            0:       e = 8'h00;
            1:       return {r[31], 8'hFF, 23'd0};
            2:       return {r[31], 8'hFF, 1'b1, r[21:0]};
            3:       return {r[31], 8'hFF, 1'b0, r[21:1], 1'b1};
            4:       e = 8'hFE - 8'($urandom % 2);
            5:       e = 8'h01 + 8'($urandom % 3);
            default: e = use_near ? near_exp + 8'($urandom % 3) - 8'd1 : 8'h01 + 8'($urandom % 254);
        endcase
        if (e == 8'hFF) e = 8'hFE;
        return {r[31], e, r[22:0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] kept;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        check("R11 reset", {out_valid, result_o, invalid_o, overflow_o, underflow_o, inexact_o}, '0);

        // R1: exact and rounded finite differences in each mode
        for (int m = 0; m < 4; m++) begin
            run_op("R1 exact", 32'h3F80_0000, 32'h3F00_0000, 1'b0, 2'(m));
            run_op("R1 tiny borrow", 32'h3F80_0000, 32'h3080_0000, 1'b0, 2'(m));
            run_op("R1 tie", 32'h4B80_0001, 32'hBF80_0000, 1'b0, 2'(m));
            run_op("R1 mixed sign", 32'hC0A0_0000, 32'h3DCC_CCCD, 1'b0, 2'(m));
        end
        // R2: like-signed cancellation
        for (int m = 0; m < 4; m++) begin
            run_op("R2 cancel pos", 32'h4049_0FDB, 32'h4049_0FDB, 1'b0, 2'(m));
            run_op("R2 cancel neg", 32'hC120_0000, 32'hC120_0000, 1'b0, 2'(m));
        end
        // R3: fixed signed-zero identities
        for (int m = 0; m < 4; m++) begin
            run_op("R3 +0 - -0", 32'h0000_0000, 32'h8000_0000, 1'b0, 2'(m));
            run_op("R3 -0 - +0", 32'h8000_0000, 32'h0000_0000, 1'b0, 2'(m));
        end
        // R4: integer zero source counts as +0
        run_op("R4 int zero near", 32'h0000_0000, 32'h8000_0000, 1'b1, 2'b00);
        run_op("R4 int zero down", 32'h0000_0000, 32'h8000_0000, 1'b1, 2'b01);
        run_op("R4 neg dest", 32'h8000_0000, 32'h8000_0000, 1'b1, 2'b10);
        run_op("R4 value", 32'h3F80_0000, 32'h8000_0000, 1'b1, 2'b01);
        // R5: one infinite operand
        run_op("R5 inf dest", 32'hFF80_0000, 32'h3F80_0000, 1'b0, 2'b00);
        run_op("R5 inf src", 32'h3F80_0000, 32'h7F80_0000, 1'b0, 2'b00);
        run_op("R5 inf src neg", 32'h0000_0000, 32'hFF80_0000, 1'b0, 2'b11);
        run_op("R6 opposite infs", 32'hFF80_0000, 32'h7F80_0000, 1'b0, 2'b00);
        // R6: like-signed infinities
        run_op("R6 +inf - +inf", 32'h7F80_0000, 32'h7F80_0000, 1'b0, 2'b00);
        run_op("R6 -inf - -inf", 32'hFF80_0000, 32'hFF80_0000, 1'b0, 2'b01);
        // R7: NaN operands
        run_op("R7 quiet", 32'h7FC0_1234, 32'h3F80_0000, 1'b0, 2'b00);
        run_op("R7 signaling", 32'h3F80_0000, 32'hFF80_0001, 1'b0, 2'b00);
        run_op("R7 quiet vs inf", 32'h7F80_0000, 32'hFFC0_0000, 1'b0, 2'b10);
        // R8: overflow saturation per mode and sign
        for (int m = 0; m < 4; m++) begin
            run_op("R8 pos ovf", 32'h7F7F_FFFF, 32'hFF7F_FFFF, 1'b0, 2'(m));
            run_op("R8 neg ovf", 32'hFF7F_FFFF, 32'h7F7F_FFFF, 1'b0, 2'(m));
            run_op("R8 round up ovf", 32'h7F7F_FFFF, 32'hF380_0000, 1'b0, 2'(m));
        end
        // R9: subnormal inputs flushed
        run_op("R9 sub vs zero", 32'h0000_0001, 32'h0000_0000, 1'b0, 2'b01);
        run_op("R9 sub source", 32'h3F80_0000, 32'h0040_0000, 1'b0, 2'b10);
        run_op("R9 neg sub", 32'h8000_0005, 32'h0000_0000, 1'b0, 2'b00);
        // R10: result below normal range
        run_op("R10 flush pos", 32'h0080_0001, 32'h0080_0000, 1'b0, 2'b00);
        run_op("R10 flush neg", 32'h0080_0000, 32'h0080_0001, 1'b0, 2'b10);
        run_op("R10 edge normal", 32'h0100_0000, 32'h0080_0000, 1'b0, 2'b00);

        // R11: outputs hold while idle
        run_op("R11 load", 32'h4000_0000, 32'h3F80_0000, 1'b0, 2'b00);
        kept = result_o;
        @(negedge clk);
        @(negedge clk);
        check("R11 hold", {out_valid, result_o}, {1'b0, kept});

        // R1: random mix with cancellation and range edges
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] d, s;
            d = gen_word(8'h80, 1'b0);
            s = gen_word(d[30:23], ($urandom % 2) == 0);
            run_op("R1 random", d, s, ($urandom % 8) == 0, 2'($urandom % 4));
        end

        finish_run();
    end

endmodule